// File: doc/BRIEF.md
# Monitor Sync Input Conditioner

This block takes the horizontal (or composite) and vertical sync inputs of a display monitor, sampled on the system clock, and turns them into clean, measured signals. A two-stage synchronizer and a run-length glitch filter come first. Each filtered input then feeds a measurement unit with four jobs. It flags whether the signal is present. It latches its period. It decides which level is the active one. It produces a copy with the active level always high. Optional divide-by-two outputs follow the rising edges of each filtered input.

The horizontal period is counted in clock cycles. The vertical period is counted in horizontal lines. When the horizontal input carries composite sync, a separator watches the active level of the normalised horizontal signal. Any active stretch longer than a threshold becomes a vertical pulse. The threshold is either given by software or, when zero, taken as a quarter of the last horizontal period. Presence timeouts and the separator threshold are inputs, so firmware can set them.

Top module: `syncp_top`

## Requirements
- R1: An input level reaches the filtered signal only after it has been sampled on FILT_TAPS (default 3) consecutive clocks, behind a two-flop synchronizer. Pulses of one or two clocks have no effect on any output.
- R2: `h_present` is set on a rising edge of the filtered horizontal input. It is cleared once `h_tmo` clocks pass without such an edge.
- R3: `v_present` follows the same rule for the selected vertical source, using `v_tmo`.
- R4: `h_period` holds the number of clocks between the last two filtered horizontal rising edges, saturating at all ones.
- R5: `v_lines` holds the number of filtered horizontal rising edges after one vertical rising edge up to and including the next, saturating at all ones.
- R6: On each rising edge of a filtered input, its polarity flag (`h_neg`, `v_neg`) becomes 1 when the signal was high on more clocks than low over the period just ended, and 0 otherwise. The flag changes at no other time.
- R7: `hs_norm` and `vs_norm` equal the filtered signal XOR its polarity flag, so the active level reads as 1.
- R8: With `half_h_en` (or `half_v_en`) at 1, `hs_half` (`vs_half`) toggles on every filtered rising edge of its input. With the enable at 0, the output is held at 0.
- R9: With `csync_mode` at 1, the vertical source is the separated pulse, not `vs_in`. The separated pulse is high while `hs_norm` is high and has been high for more than the limit. The limit is `csep_thr`, or `h_period`/4 when `csep_thr` is 0. Each over-limit horizontal pulse yields one separated pulse.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_in | input | 1 | Horizontal or composite sync input |
| vs_in | input | 1 | Vertical sync input |
| csync_mode | input | 1 | 1: take vertical from composite separation |
| half_h_en | input | 1 | Enable for `hs_half` |
| half_v_en | input | 1 | Enable for `vs_half` |
| h_tmo | input | TMO_W | Horizontal absence timeout in clocks |
| v_tmo | input | TMO_W | Vertical absence timeout in clocks |
| csep_thr | input | HCNT_W | Separation limit in clocks, 0 = automatic |
| h_present | output | 1 | Horizontal input present |
| v_present | output | 1 | Vertical source present |
| h_neg | output | 1 | Horizontal polarity is negative |
| v_neg | output | 1 | Vertical polarity is negative |
| h_period | output | HCNT_W | Horizontal period in clocks |
| v_lines | output | VCNT_W | Vertical period in lines |
| hs_norm | output | 1 | Horizontal sync, active high |
| vs_norm | output | 1 | Vertical sync, active high |
| hs_half | output | 1 | Horizontal half-rate output |
| vs_half | output | 1 | Vertical half-rate output |

## Verification
The assertions assume a few things about the sync inputs. Each input is a periodic pulse train whose high and low times are never equal, so the polarity decision is never a tie. Vertical rising edges coincide with horizontal rising edges on the same clock, so the line count is exact. In composite mode, the widened serration pulses stay shorter than half a line, so the horizontal polarity does not flip inside the vertical interval. The stimulus generator builds every waveform from one line counter and one clock counter. Vertical transitions are placed only at line starts with positive horizontal polarity. Random pulse widths are nudged away from the exact half period.

// File: rtl/syncp_pkg.sv
package syncp_pkg;
    // Depth of the metastability synchronizer ahead of each glitch filter.
    localparam int unsigned SYNC_STAGES = 2;

    // Source of the vertical timing information.
    typedef enum logic {
        VSRC_PIN       = 1'b0,
        VSRC_COMPOSITE = 1'b1
    } vsrc_e;
endpackage

// File: rtl/syncp_filter.sv
module syncp_filter
    import syncp_pkg::*;
#(
    parameter int unsigned TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned SHW = SYNC_STAGES + TAPS;

    typedef struct packed {
        logic [SHW-1:0] sh;
        logic           lvl;
    } st_t;

    st_t q, d;
    logic [TAPS-1:0] taps;

    always_comb begin
        d    = q;
        taps = q.sh[SHW-1:SYNC_STAGES];
        d.sh = {q.sh[SHW-2:0], raw_i};
        if (&taps) begin
            d.lvl = 1'b1;
        end else if (~|taps) begin
            d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.lvl;

    // R1: the filtered level only moves after a full run of equal samples
    a_r1_run_before_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.lvl) |-> ($past(q.sh[SHW-1:SYNC_STAGES]) == {TAPS{q.lvl}}));
endmodule

// File: rtl/syncp_meas.sv
module syncp_meas #(
    parameter int unsigned CW = 16,
    parameter int unsigned TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    input  logic          tick_i,
    input  logic [TW-1:0] tmo_i,
    output logic          edge_o,
    output logic          present_o,
    output logic          neg_o,
    output logic [CW-1:0] period_o,
    output logic          norm_o
);
    localparam logic [TW:0] DIFF_MAX = {1'b0, {TW{1'b1}}};
    localparam logic [TW:0] DIFF_MIN = {1'b1, {TW{1'b0}}};

    typedef struct packed {
        logic          prev;
        logic          present;
        logic          neg;
        logic [CW-1:0] cnt;
        logic [CW-1:0] period;
        logic [TW-1:0] idle;
        logic [TW:0]   diff;
    } st_t;

    st_t q, d;
    logic edge_w;
    logic [CW-1:0] cnt_inc;

    assign edge_w  = lvl_i & ~q.prev;
    assign cnt_inc = (tick_i && (q.cnt != '1)) ? q.cnt + 1'b1 : q.cnt;

    always_comb begin
        d      = q;
        d.prev = lvl_i;
        if (edge_w) begin
            d.present = 1'b1;
            d.idle    = '0;
            d.neg     = !q.diff[TW] && (q.diff != '0);
            d.diff    = {{TW{1'b0}}, 1'b1};
            d.period  = cnt_inc;
            d.cnt     = '0;
        end else begin
            if (q.idle >= tmo_i) begin
                d.present = 1'b0;
            end else begin
                d.idle = q.idle + 1'b1;
            end
            if (lvl_i) begin
                if (q.diff != DIFF_MAX) d.diff = q.diff + 1'b1;
            end else begin
                if (q.diff != DIFF_MIN) d.diff = q.diff - 1'b1;
            end
            d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign edge_o    = edge_w;
    assign present_o = q.present;
    assign neg_o     = q.neg;
    assign period_o  = q.period;
    assign norm_o    = lvl_i ^ q.neg;

    // R2 / R3: presence is only ever raised by a rising edge
    a_r2_present_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.present) |-> $past(edge_w));
    // R4 / R5: the latched period holds between edges
    a_r4_period_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_w |=> $stable(q.period));
    // R6: the polarity flag only changes at an edge
    a_r6_polarity_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_w |=> $stable(q.neg));
endmodule

// File: rtl/syncp_csep.sv
module syncp_csep #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic [CW-1:0] hper_i,
    input  logic [CW-1:0] thr_i,
    output logic          vsep_o
);
    typedef struct packed {
        logic [CW-1:0] run;
        logic          vsep;
    } st_t;

    st_t q, d;
    logic [CW-1:0] limit;

    always_comb begin
        d     = q;
        limit = (thr_i == '0) ? (hper_i >> 2) : thr_i;
        if (act_i) begin
            if (q.run != '1) d.run = q.run + 1'b1;
        end else begin
            d.run = '0;
        end
        d.vsep = act_i && (d.run > limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vsep_o = q.vsep;

    // R9: a separated pulse never outlives the active horizontal level
    a_r9_sep_within_active: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> !q.vsep);
endmodule

// File: rtl/syncp_half.sv
module syncp_half (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic edge_i,
    output logic half_o
);
    logic half_d, half_q;

    always_comb begin
        half_d = 1'b0;
        if (en_i) half_d = edge_i ? ~half_q : half_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= half_d;
    end

    assign half_o = half_q;

    // R8: disabled output parks low, enabled output flips on each edge
    a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !half_q);
    a_r8_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && edge_i) |=> (half_q != $past(half_q)));
endmodule

// File: rtl/syncp_top.sv
module syncp_top
    import syncp_pkg::*;
#(
    parameter int unsigned HCNT_W    = 16,
    parameter int unsigned VCNT_W    = 12,
    parameter int unsigned TMO_W     = 20,
    parameter int unsigned FILT_TAPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic              csync_mode,
    input  logic              half_h_en,
    input  logic              half_v_en,
    input  logic [TMO_W-1:0]  h_tmo,
    input  logic [TMO_W-1:0]  v_tmo,
    input  logic [HCNT_W-1:0] csep_thr,
    output logic              h_present,
    output logic              v_present,
    output logic              h_neg,
    output logic              v_neg,
    output logic [HCNT_W-1:0] h_period,
    output logic [VCNT_W-1:0] v_lines,
    output logic              hs_norm,
    output logic              vs_norm,
    output logic              hs_half,
    output logic              vs_half
);
    localparam int unsigned NCH = 2;

    logic [NCH-1:0] raw, filt;
    logic h_edge, v_edge, vsep, v_lvl;
    vsrc_e vsrc;

    assign raw = {vs_in, hs_in};

    for (genvar i = 0; i < NCH; i++) begin : g_filt
        syncp_filter #(.TAPS(FILT_TAPS)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw[i]), .level_o(filt[i])
        );
    end

    syncp_meas #(.CW(HCNT_W), .TW(TMO_W)) u_hmeas (
        .clk(clk), .rst_n(rst_n), .lvl_i(filt[0]), .tick_i(1'b1), .tmo_i(h_tmo),
        .edge_o(h_edge), .present_o(h_present), .neg_o(h_neg),
        .period_o(h_period), .norm_o(hs_norm)
    );

    syncp_csep #(.CW(HCNT_W)) u_csep (
        .clk(clk), .rst_n(rst_n), .act_i(hs_norm), .hper_i(h_period),
        .thr_i(csep_thr), .vsep_o(vsep)
    );

    assign vsrc  = csync_mode ? VSRC_COMPOSITE : VSRC_PIN;
    assign v_lvl = (vsrc == VSRC_COMPOSITE) ? vsep : filt[1];

    syncp_meas #(.CW(VCNT_W), .TW(TMO_W)) u_vmeas (
        .clk(clk), .rst_n(rst_n), .lvl_i(v_lvl), .tick_i(h_edge), .tmo_i(v_tmo),
        .edge_o(v_edge), .present_o(v_present), .neg_o(v_neg),
        .period_o(v_lines), .norm_o(vs_norm)
    );

    syncp_half u_hhalf (
        .clk(clk), .rst_n(rst_n), .en_i(half_h_en), .edge_i(h_edge), .half_o(hs_half)
    );

    syncp_half u_vhalf (
        .clk(clk), .rst_n(rst_n), .en_i(half_v_en), .edge_i(v_edge), .half_o(vs_half)
    );

    // R10: all outputs are quiet while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!h_present && !v_present && !hs_half && !vs_half
                                       && h_period == '0 && v_lines == '0);
        end
    end
endmodule

// File: tb/syncp_top_test.sv
`timescale 1ns/1ps
module syncp_top_test;
    localparam int HW = 10;
    localparam int VW = 4;
    localparam int TW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_in = 1'b0, vs_in = 1'b0;
    logic csync_mode = 1'b0, half_h_en = 1'b0, half_v_en = 1'b0;
    logic [TW-1:0] h_tmo = TW'(2000), v_tmo = TW'(3000);
    logic [HW-1:0] csep_thr = '0;
    logic h_present, v_present, h_neg, v_neg, hs_norm, vs_norm, hs_half, vs_half;
    logic [HW-1:0] h_period;
    logic [VW-1:0] v_lines;

    syncp_top #(.HCNT_W(HW), .VCNT_W(VW), .TMO_W(TW), .FILT_TAPS(3)) uut (
        .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
        .csync_mode(csync_mode), .half_h_en(half_h_en), .half_v_en(half_v_en),
        .h_tmo(h_tmo), .v_tmo(v_tmo), .csep_thr(csep_thr),
        .h_present(h_present), .v_present(v_present), .h_neg(h_neg), .v_neg(v_neg),
        .h_period(h_period), .v_lines(v_lines), .hs_norm(hs_norm), .vs_norm(vs_norm),
        .hs_half(hs_half), .vs_half(vs_half)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // waveform generator settings
    bit gen_on = 0, comp = 0;
    int hp = 20, hw = 3, hpol = 0, serr = 18, vl = 1, vwl = 0, vpol = 0;
    int hc = 0, ln = 0, aw = 0;
    logic ha, va;

    // measurement results
    int hn_hi, vn_hi, hh_tog, vh_tog, vn_rise;

    initial forever begin
        @(negedge clk);
        if (!gen_on) begin
            hs_in = 1'b0; vs_in = 1'b0; hc = 0; ln = 0;
        end else begin
            aw = (comp && ln < vwl) ? serr : hw;
            ha = (hc < aw);
            va = (ln < vwl);
            hs_in = hpol[0] ? ~ha : ha;
            vs_in = comp ? 1'b0 : (vpol[0] ? ~va : va);
            hc++;
            if (hc >= hp) begin
                hc = 0; ln++;
                if (ln >= vl) ln = 0;
            end
        end
    end

    function automatic int exp_neg(int per, int hi);
        return (2 * hi > per) ? 1 : 0;
    endfunction

    function automatic int exp_norm_hi(int per, int hi);
        return exp_neg(per, hi) ? per - hi : hi;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(int n);
        logic ph, pv, pn;
        hn_hi = 0; vn_hi = 0; hh_tog = 0; vh_tog = 0; vn_rise = 0;
        ph = hs_half; pv = vs_half; pn = vs_norm;
        repeat (n) begin
            @(negedge clk);
            if (hs_norm) hn_hi++;
            if (vs_norm) vn_hi++;
            if (hs_half != ph) hh_tog++;
            if (vs_half != pv) vh_tog++;
            if (vs_norm && !pn) vn_rise++;
            ph = hs_half; pv = vs_half; pn = vs_norm;
        end
    endtask

    initial begin
        int seed;
        int hi, lines_hi;
        seed = $urandom(32'd2024);

        // R10: reset state
        wc(5);
        chk("R10 h_present", int'(h_present), 0);
        chk("R10 v_present", int'(v_present), 0);
        chk("R10 h_period", int'(h_period), 0);
        chk("R10 v_lines", int'(v_lines), 0);
        chk("R10 hs_half", int'(hs_half), 0);
        rst_n = 1'b1;
        wc(3);

        // R1: one- and two-clock pulses are rejected
        hp = 20; hw = 1; hpol = 0; vwl = 0; vpol = 0; vl = 1; gen_on = 1;
        wc(100); measure(100);
        chk("R1 one-clock hs_norm highs", hn_hi, 0);
        chk("R1 one-clock h_present", int'(h_present), 0);
        hw = 2;
        wc(100); measure(100);
        chk("R1 two-clock hs_norm highs", hn_hi, 0);
        chk("R1 two-clock h_present", int'(h_present), 0);
        hw = 3;
        wc(100);
        chk("R1 R2 three-clock h_present", int'(h_present), 1);
        chk("R1 R4 three-clock h_period", int'(h_period), 20);

        // R4 R6 R7: random horizontal trains
        for (int it = 0; it < 8; it++) begin
            hp = 24 + int'($urandom % 177);
            hw = 3 + int'($urandom % (hp - 5));
            hpol = int'($urandom % 2);
            hi = hpol ? hp - hw : hw;
            if (2 * hi == hp) begin hw++; hi = hpol ? hp - hw : hw; end
            wc(4 * hp + 20);
            measure(hp);
            chk("R4 h_period", int'(h_period), hp);
            chk("R6 h_neg", int'(h_neg), exp_neg(hp, hi));
            chk("R7 hs_norm high time", hn_hi, exp_norm_hi(hp, hi));
            chk("R2 h_present", int'(h_present), 1);
        end

        // R4: saturation
        hp = 1100; hw = 10; hpol = 0;
        wc(3 * 1100);
        chk("R4 h_period saturates", int'(h_period), (1 << HW) - 1);

        // R8: horizontal half rate
        hp = 40; hw = 5; half_h_en = 1;
        wc(200); measure(400);
        chk("R8 hs_half toggles", hh_tog, 10);
        half_h_en = 0;
        wc(2); measure(200);
        chk("R8 hs_half disabled toggles", hh_tog, 0);
        chk("R8 hs_half disabled level", int'(hs_half), 0);

        // R5 R6 R7 R8: vertical trains aligned to line starts
        hp = 20; hw = 3; hpol = 0; half_v_en = 1;
        for (int it = 0; it < 4; it++) begin
            vl = 4 + int'($urandom % 9);
            vwl = 1 + int'($urandom % (vl - 1));
            vpol = int'($urandom % 2);
            lines_hi = vpol ? vl - vwl : vwl;
            if (2 * lines_hi == vl) begin vwl++; lines_hi = vpol ? vl - vwl : vwl; end
            wc(3 * vl * hp + 20);
            measure(2 * vl * hp);
            chk("R5 v_lines", int'(v_lines), vl);
            chk("R6 v_neg", int'(v_neg), exp_neg(vl, lines_hi));
            chk("R7 vs_norm high time", vn_hi, 2 * hp * exp_norm_hi(vl, lines_hi));
            chk("R8 vs_half toggles", vh_tog, 2);
            chk("R3 v_present", int'(v_present), 1);
        end

        // R5: saturation of line count
        vl = 20; vwl = 2; vpol = 0;
        wc(3 * 20 * 20);
        chk("R5 v_lines saturates", int'(v_lines), (1 << VW) - 1);

        // R2 R3: timeouts once inputs stop
        gen_on = 0;
        wc(2100);
        chk("R2 h_present after timeout", int'(h_present), 0);
        wc(1000);
        chk("R3 v_present after timeout", int'(v_present), 0);

        // R9: composite separation, automatic limit
        half_v_en = 0;
        csync_mode = 1; comp = 1; csep_thr = '0;
        hp = 40; hw = 4; hpol = 1; serr = 18; vl = 8; vwl = 2;
        gen_on = 1;
        wc(4 * 8 * 40);
        measure(8 * 40);
        chk("R9 auto v_present", int'(v_present), 1);
        chk("R9 auto v_neg", int'(v_neg), 0);
        chk("R9 auto separated pulses per frame", vn_rise, 2);
        chk("R6 composite h_neg", int'(h_neg), 1);

        // R9: explicit limit above the serration width
        csep_thr = HW'(20);
        wc(3400);
        measure(8 * 40);
        chk("R9 thr20 separated pulses", vn_rise, 0);
        chk("R9 R3 thr20 v_present", int'(v_present), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule